// File: doc/BRIEF.md
# FPGA Configuration Handshake Sequencer

This block takes a downstream programmable device through a serial configuration load. On a start pulse it drives the device's program pin high for one microsecond tick and then pulls it low. This clears the target. It then waits for the target's init-status input to fall. Next it releases the program pin and waits for init-status to rise again. After that it pulls configuration bytes from a valid/ready stream and sends each one out most-significant bit first on a serial clock/data pin pair. When the last byte has gone out, it waits for the done-status input. Each of these three waits has its own timeout, counted in microsecond ticks.

After done rises, the block applies a reset to the loaded logic through the same pins. The program and serial clock pins are held high with data low for one hold window, and then data is raised for a second hold window. The block then reports success. If a wait runs out, the block stops at once and reports a two-bit code that names the phase that failed. Both success and the error code stay unchanged until the next start pulse.

Back-pressure on the byte stream: `s_ready` is high only while the shift phase is active and the shifter holds no byte. A byte is taken on a cycle where `s_valid` and `s_ready` are both high. A source that is stalled must hold `s_data` and `s_last` steady. The byte flagged with `s_last` ends the load.

Top module: `cfg_load_seq`

## Requirements
- R1: A start pulse while idle raises `busy` on the next clock edge and clears `success` and `err_code` to 0. `prog_o` stays high for the first tick and is then driven low. `prog_o` is never low while the block is idle.
- R2: While `prog_o` is low, if `init_i` stays high for TO_INIT_LOW ticks, the sequence ends with `err_code` = 1. `busy` is then high for exactly 1 + TO_INIT_LOW ticks.
- R3: Once `init_i` is low, `prog_o` is released. If `init_i` does not return high within TO_INIT_HIGH ticks, the sequence ends with `err_code` = 2 and no byte is taken.
- R4: `s_ready` is high only while the block is busy in the shift phase with an empty shifter. A byte moves only when `s_valid` and `s_ready` are both high. Every byte up to and including the one marked `s_last` is sent, and no later byte is sent.
- R5: Each byte is sent MSB first as one `cclk_o` pulse per bit. `cdata_o` holds the bit for one tick with `cclk_o` low, and then stays stable through one tick with `cclk_o` high.
- R6: After the last bit, if `done_i` does not rise within TO_DONE ticks, the sequence ends with `err_code` = 3.
- R7: After `done_i` rises, `prog_o` and `cclk_o` are held high with `cdata_o` low for HOLD_TICKS ticks. Then `cdata_o` is held high for another HOLD_TICKS ticks.
- R8: At the end of a sequence, `busy` falls in the same cycle that exactly one of two things appears: `success` = 1 with `err_code` = 0, or `success` = 0 with a nonzero `err_code`.
- R9: While idle, `success` and `err_code` (0 = none) hold their values until the next start pulse.
- R10: A start pulse while `busy` is high is ignored, and the load in progress completes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to begin a load |
| tick_us | input | 1 | One-cycle pulse per microsecond |
| s_data | input | BYTE_W | Configuration byte |
| s_valid | input | 1 | Byte on `s_data` is valid |
| s_last | input | 1 | Byte on `s_data` is the final one |
| s_ready | output | 1 | Block accepts a byte this cycle |
| init_i | input | 1 | Target init-status pin |
| done_i | input | 1 | Target done-status pin |
| prog_o | output | 1 | Target program pin, low clears the target |
| cclk_o | output | 1 | Serial configuration clock |
| cdata_o | output | 1 | Serial configuration data |
| busy | output | 1 | A sequence is in progress |
| success | output | 1 | Last sequence completed |
| err_code | output | 2 | Failed phase: 0 none, 1 init-low, 2 init-high, 3 done |

## Verification
The assertions rely on three properties of the inputs. `rst_n` is low from time zero. `tick_us` is a single-cycle pulse with idle cycles between pulses. A stalled stream source holds its byte until it is accepted, so a serial clock edge never meets a data bit that changes in the same cycle. The bench produces a tick every fourth clock and gives `start` for one cycle only. It changes stream inputs only on falling clock edges, and only after it has seen `s_ready` high. Its target model derives init-status and done-status from the pins the block drives, so the handshake never sees an input change that the block has not caused.

// File: rtl/cfg_load_pkg.sv
package cfg_load_pkg;

  typedef enum logic [1:0] {
    ERR_NONE      = 2'd0,
    ERR_INIT_LOW  = 2'd1,
    ERR_INIT_HIGH = 2'd2,
    ERR_DONE      = 2'd3
  } cfg_err_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_PROG_LOW,
    ST_RELEASE,
    ST_SHIFT,
    ST_WAIT_DONE,
    ST_POST_LO,
    ST_POST_HI
  } cfg_state_e;

  typedef enum logic [1:0] {
    SH_EMPTY,
    SH_SETUP,
    SH_HIGH
  } sh_phase_e;

endpackage

// File: rtl/cfg_tick_timer.sv
module cfg_tick_timer #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  // fires on the tick that completes `limit` ticks since the last clear
  assign expired = tick && (cnt_q == limit - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

endmodule

// File: rtl/cfg_bit_shifter.sv
module cfg_bit_shifter
  import cfg_load_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_valid,
  input  logic              s_last,
  output logic              s_ready,
  output logic              ser_clk,
  output logic              ser_data,
  output logic              stream_end
);

  localparam int IDX_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BYTE_W - 1);

  sh_phase_e         phase_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [IDX_W-1:0]  idx_q;
  logic              last_q;

  assign s_ready    = en && (phase_q == SH_EMPTY);
  assign ser_clk    = (phase_q == SH_HIGH);
  assign ser_data   = (phase_q != SH_EMPTY) ? shreg_q[BYTE_W-1] : 1'b0;
  assign stream_end = (phase_q == SH_HIGH) && tick && (idx_q == LAST_IDX) && last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= SH_EMPTY;
      shreg_q <= '0;
      idx_q   <= '0;
      last_q  <= 1'b0;
    end else begin
      unique case (phase_q)
        SH_EMPTY: begin
          if (s_valid && s_ready) begin
            shreg_q <= s_data;
            last_q  <= s_last;
            idx_q   <= '0;
            phase_q <= SH_SETUP;
          end
        end
        SH_SETUP: begin
          if (tick) phase_q <= SH_HIGH;
        end
        SH_HIGH: begin
          if (tick) begin
            if (idx_q == LAST_IDX) begin
              phase_q <= SH_EMPTY;
            end else begin
              shreg_q <= {shreg_q[BYTE_W-2:0], 1'b0};
              idx_q   <= idx_q + IDX_W'(1);
              phase_q <= SH_SETUP;
            end
          end
        end
        default: phase_q <= SH_EMPTY;
      endcase
    end
  end

endmodule

// File: rtl/cfg_seq_fsm.sv
module cfg_seq_fsm
  import cfg_load_pkg::*;
#(
  parameter int CNT_W        = 10,
  parameter int TO_INIT_LOW  = 1000,
  parameter int TO_INIT_HIGH = 1000,
  parameter int TO_DONE      = 1000,
  parameter int HOLD_TICKS   = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             init_i,
  input  logic             done_i,
  input  logic             expired,
  input  logic             stream_end,
  output logic             tmr_clr,
  output logic [CNT_W-1:0] limit,
  output logic             shift_en,
  output logic             post_on,
  output logic             post_hi,
  output logic             prog_o,
  output logic             busy,
  output logic             success,
  output cfg_err_e         err_code
);

  cfg_state_e state_q, state_d;
  cfg_err_e   err_q, fail_code;
  logic       ok_q, fail, finish;

  always_comb begin
    state_d   = state_q;
    fail      = 1'b0;
    finish    = 1'b0;
    fail_code = ERR_NONE;
    unique case (state_q)
      ST_IDLE:      if (start) state_d = ST_PRE;
      ST_PRE:       if (expired) state_d = ST_PROG_LOW;
      ST_PROG_LOW: begin
        if (!init_i) begin
          state_d = ST_RELEASE;
        end else if (expired) begin
          fail = 1'b1; fail_code = ERR_INIT_LOW; state_d = ST_IDLE;
        end
      end
      ST_RELEASE: begin
        if (init_i) begin
          state_d = ST_SHIFT;
        end else if (expired) begin
          fail = 1'b1; fail_code = ERR_INIT_HIGH; state_d = ST_IDLE;
        end
      end
      ST_SHIFT:     if (stream_end) state_d = ST_WAIT_DONE;
      ST_WAIT_DONE: begin
        if (done_i) begin
          state_d = ST_POST_LO;
        end else if (expired) begin
          fail = 1'b1; fail_code = ERR_DONE; state_d = ST_IDLE;
        end
      end
      ST_POST_LO:   if (expired) state_d = ST_POST_HI;
      ST_POST_HI: begin
        if (expired) begin
          finish = 1'b1; state_d = ST_IDLE;
        end
      end
      default:      state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (state_q)
      ST_PRE:                 limit = CNT_W'(1);
      ST_PROG_LOW:            limit = CNT_W'(TO_INIT_LOW);
      ST_RELEASE:             limit = CNT_W'(TO_INIT_HIGH);
      ST_WAIT_DONE:           limit = CNT_W'(TO_DONE);
      ST_POST_LO, ST_POST_HI: limit = CNT_W'(HOLD_TICKS);
      default:                limit = CNT_W'(1);
    endcase
  end

  // restart the tick window on every phase change
  assign tmr_clr  = (state_d != state_q) || (state_q == ST_IDLE);
  assign shift_en = (state_q == ST_SHIFT);
  assign post_on  = (state_q == ST_POST_LO) || (state_q == ST_POST_HI);
  assign post_hi  = (state_q == ST_POST_HI);
  assign prog_o   = (state_q != ST_PROG_LOW);
  assign busy     = (state_q != ST_IDLE);
  assign success  = ok_q;
  assign err_code = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      ok_q    <= 1'b0;
      err_q   <= ERR_NONE;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && start) begin
        ok_q  <= 1'b0;
        err_q <= ERR_NONE;
      end else if (finish) begin
        ok_q  <= 1'b1;
      end else if (fail) begin
        err_q <= fail_code;
      end
    end
  end

endmodule

// File: rtl/cfg_load_seq.sv
module cfg_load_seq
  import cfg_load_pkg::*;
#(
  parameter int BYTE_W       = 8,
  parameter int TO_INIT_LOW  = 1000,
  parameter int TO_INIT_HIGH = 1000,
  parameter int TO_DONE      = 1000,
  parameter int HOLD_TICKS   = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              tick_us,
  input  logic [BYTE_W-1:0] s_data,
  input  logic              s_valid,
  input  logic              s_last,
  output logic              s_ready,
  input  logic              init_i,
  input  logic              done_i,
  output logic              prog_o,
  output logic              cclk_o,
  output logic              cdata_o,
  output logic              busy,
  output logic              success,
  output logic [1:0]        err_code
);

  localparam int MAX_A   = (TO_INIT_LOW > TO_INIT_HIGH) ? TO_INIT_LOW : TO_INIT_HIGH;
  localparam int MAX_B   = (TO_DONE > HOLD_TICKS) ? TO_DONE : HOLD_TICKS;
  localparam int MAX_LIM = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W   = $clog2(MAX_LIM + 1);

  logic             tmr_clr, expired, stream_end;
  logic [CNT_W-1:0] limit;
  logic             shift_en, post_on, post_hi;
  logic             sh_clk, sh_data;
  cfg_err_e         err_e;

  cfg_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (tmr_clr),
    .tick    (tick_us),
    .limit   (limit),
    .expired (expired)
  );

  cfg_bit_shifter #(.BYTE_W(BYTE_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (shift_en),
    .tick       (tick_us),
    .s_data     (s_data),
    .s_valid    (s_valid),
    .s_last     (s_last),
    .s_ready    (s_ready),
    .ser_clk    (sh_clk),
    .ser_data   (sh_data),
    .stream_end (stream_end)
  );

  cfg_seq_fsm #(
    .CNT_W        (CNT_W),
    .TO_INIT_LOW  (TO_INIT_LOW),
    .TO_INIT_HIGH (TO_INIT_HIGH),
    .TO_DONE      (TO_DONE),
    .HOLD_TICKS   (HOLD_TICKS)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .init_i     (init_i),
    .done_i     (done_i),
    .expired    (expired),
    .stream_end (stream_end),
    .tmr_clr    (tmr_clr),
    .limit      (limit),
    .shift_en   (shift_en),
    .post_on    (post_on),
    .post_hi    (post_hi),
    .prog_o     (prog_o),
    .busy       (busy),
    .success    (success),
    .err_code   (err_e)
  );

  // pins: shifter drives them while shifting, the post reset pattern after done
  assign cclk_o   = shift_en ? sh_clk  : post_on;
  assign cdata_o  = shift_en ? sh_data : post_hi;
  assign err_code = err_e;

endmodule

// File: rtl/cfg_load_seq_chk.sv
module cfg_load_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       s_ready,
  input logic       prog_o,
  input logic       cclk_o,
  input logic       cdata_o,
  input logic       busy,
  input logic       success,
  input logic [1:0] err_code
);

  // R1: the sequence opens with the program pin high
  p_prog_high_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> prog_o);

  // R1: the program pin is only pulled low inside a sequence
  p_pulldown_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_o |-> busy);

  // R4: bytes are only taken while busy with the program pin released
  p_ready_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (busy && prog_o));

  // R5: data is already in place when the serial clock rises
  p_setup_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cclk_o) |-> $stable(cdata_o));

  // R8: ending a sequence yields exactly one outcome
  p_outcome_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (success != (err_code != 2'd0)));

  // R8: success never carries an error code
  p_success_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    success |-> (err_code == 2'd0));

  // R9: results hold while idle without a start
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(err_code) && $stable(success)));

  // R10: a start while busy does not clear an outcome or abort
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> (busy || success || (err_code != 2'd0)));

endmodule

bind cfg_load_seq cfg_load_seq_chk u_chk (.*);

// File: tb/cfg_load_seq_bench.sv
module cfg_load_seq_bench;

  localparam int TO_IL = 20;
  localparam int TO_IH = 20;
  localparam int TO_D  = 20;
  localparam int HOLD  = 10;
  localparam int NVEC  = 7;

  // [9] init never falls, [8] init never returns, [7] done never rises,
  // [6] gappy source, [5] start poke while busy, [4:2] bytes, [1:0] expected code
  localparam logic [9:0] VEC [NVEC] = '{
    10'b0_0_0_0_0_001_00,
    10'b0_0_0_0_1_011_00,
    10'b1_0_0_0_0_010_01,
    10'b0_1_0_0_0_010_10,
    10'b0_0_1_0_0_010_11,
    10'b0_0_0_1_0_100_00,
    10'b0_0_0_0_0_010_00
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic tick_us = 1'b0;
  logic [7:0] s_data = '0;
  logic s_valid = 1'b0;
  logic s_last = 1'b0;
  logic s_ready, init_i, prog_o, cclk_o, cdata_o, busy, success;
  logic done_i = 1'b0;
  logic [1:0] err_code;

  logic fail_low = 1'b0, fail_high = 1'b0, fail_done = 1'b0;
  logic prog_low_seen = 1'b0, cclk_prev = 1'b0;
  int   nbytes = 0, bits_seen = 0, busy_ticks = 0, post_lo = 0, post_hi = 0;
  int   tdiv = 0, cyc = 0, n_chk = 0, n_bad = 0;
  logic [7:0] cap [8];

  always #2.5 clk = ~clk;

  cfg_load_seq #(
    .BYTE_W(8), .TO_INIT_LOW(TO_IL), .TO_INIT_HIGH(TO_IH),
    .TO_DONE(TO_D), .HOLD_TICKS(HOLD)
  ) u_cfg_load_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tick_us(tick_us),
    .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
    .init_i(init_i), .done_i(done_i), .prog_o(prog_o), .cclk_o(cclk_o),
    .cdata_o(cdata_o), .busy(busy), .success(success), .err_code(err_code)
  );

  // target model: init follows the program pin unless told to stall
  assign init_i = fail_low ? 1'b1 :
                  (!prog_o ? 1'b0 : (prog_low_seen ? !fail_high : 1'b1));

  always @(negedge clk) begin
    cyc++;
    tdiv = (tdiv + 1) % 4;
    tick_us = (tdiv == 0);
    if (tick_us && busy) busy_ticks++;
    if (tick_us && busy && done_i && cclk_o && prog_o && !cdata_o) post_lo++;
    if (tick_us && busy && done_i && cclk_o && prog_o && cdata_o) post_hi++;
    if (!prog_o) prog_low_seen = 1'b1;
    if (cclk_o && !cclk_prev && !done_i) begin
      if (bits_seen < 64) cap[bits_seen / 8][7 - (bits_seen % 8)] = cdata_o;
      bits_seen++;
    end
    cclk_prev = cclk_o;
    if (!fail_done && !cclk_o && prog_low_seen && nbytes > 0 && bits_seen == nbytes * 8)
      done_i = 1'b1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int v, input int i);
    return 8'((32'hA5 ^ (v * 37) ^ (i * 91)) & 32'hFF);
  endfunction

  task automatic feed(input int v, input int n, input bit gappy);
    for (int i = 0; i < n; i++) begin
      if (gappy) repeat (3) @(negedge clk);
      s_data  = pat(v, i);
      s_last  = (i == n - 1);
      s_valid = 1'b1;
      while (1) begin
        if (!busy) begin
          s_valid = 1'b0;
          return;
        end
        if (s_ready) begin
          @(negedge clk);
          break;
        end
        @(negedge clk);
      end
      s_valid = 1'b0;
    end
  endtask

  task automatic run_vec(input int v);
    logic [9:0] e;
    int         exp_err;
    logic [1:0] held;
    logic       okb;
    e = VEC[v];
    exp_err = int'(e[1:0]);
    nbytes  = int'(e[4:2]);
    fail_low = e[9]; fail_high = e[8]; fail_done = e[7];
    done_i = 1'b0; prog_low_seen = 1'b0; bits_seen = 0;
    busy_ticks = 0; post_lo = 0; post_hi = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R1: first busy cycle shows cleared outcome and program pin high
    chk(busy && prog_o, "R1", "busy/prog after start", int'({busy, prog_o}), 3);
    chk(!success && err_code == 2'd0, "R1", "outcome cleared", int'({success, err_code}), 0);
    fork
      feed(v, nbytes, e[6]);
      if (e[5]) begin
        repeat (40) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    join
    while (busy) @(negedge clk);
    chk(err_code == exp_err[1:0], (exp_err == 1) ? "R2" : (exp_err == 2) ? "R3" :
        (exp_err == 3) ? "R6" : "R8", "error code", int'(err_code), exp_err);
    chk(success == (exp_err == 0), "R8", "success at busy fall", int'(success),
        int'(exp_err == 0));
    if (exp_err == 1) begin
      chk(busy_ticks == 1 + TO_IL, "R2", "ticks busy", busy_ticks, 1 + TO_IL);
    end
    if (exp_err == 1 || exp_err == 2) begin
      chk(bits_seen == 0, "R3", "bits sent without init", bits_seen, 0);
    end
    if (exp_err == 0 || exp_err == 3) begin
      chk(bits_seen == nbytes * 8, "R4", "bit count", bits_seen, nbytes * 8);
      okb = 1'b1;
      for (int i = 0; i < nbytes; i++) if (cap[i] !== pat(v, i)) okb = 1'b0;
      chk(okb, "R5", "msb-first bytes", int'(cap[0]), int'(pat(v, 0)));
    end
    if (exp_err == 0) begin
      chk(post_lo == HOLD, "R7", "post data-low ticks", post_lo, HOLD);
      chk(post_hi == HOLD, "R7", "post data-high ticks", post_hi, HOLD);
      if (e[5]) chk(success, "R10", "start while busy ignored", int'(success), 1);
    end
    held = err_code;
    repeat (30) @(negedge clk);
    chk(err_code == held && success == (exp_err == 0), "R9", "outcome held idle",
        int'(err_code), int'(held));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !success && err_code == 2'd0, "R8", "reset outcome",
        int'({busy, success, err_code}), 0);
    chk(prog_o && !cclk_o && !cdata_o, "R1", "reset pins",
        int'({prog_o, cclk_o, cdata_o}), 4);
    chk(!s_ready, "R4", "ready in reset", int'(s_ready), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!s_ready && prog_o && !busy, "R4", "idle ready/prog", int'({s_ready, prog_o}), 1);
    for (int v = 0; v < NVEC; v++) run_vec(v);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule